// File: doc/BRIEF.md
# Display Mode Switch Delay Controller

This block sits in the pixel pipeline of a video chip, between the priority register and the pixel decoder. Software writes a two-bit display-mode field. The field selects the normal high-resolution playfield mode or one of three special modes: 16 luminances, 9 colours, or 16 hues. The new value does not reach the pixel path at once. The block holds each change back by a delay that depends on the mode being left and the mode being entered. It then hands the pixel path one effective mode per color-clock slot. Some exits from a special mode produce a defined one- or two-slot artifact rather than a clean cut, and the block flags those slots with qualifiers aligned to the mode output.

Each accepted write becomes a scheduled change that carries a target horizontal position. The position is the write position plus the transition delay, modulo the line length. Scheduled changes wait in a small in-order queue. A slot state machine applies the head change when the incoming horizontal position reaches its target. It has three states: `ST_IDLE` (no change pending), `ST_ARMED` (a change is waiting for its slot) and `ST_REPEAT` (the slot after a half-pixel cut, which repeats the previous data). The transitions are as follows. IDLE goes to ARMED when the queue holds a change. ARMED goes to REPEAT when a wide-mode exit hits its slot. ARMED goes back to IDLE once the queue is empty. REPEAT goes to ARMED on the next color clock.

While any special mode is effective, it overrides the display-list processor's high-resolution request.

Top module: `mode_switch_delay`

## Requirements
- R1: After reset, mode_eff is 00 and hires_eff, half_cut, pf_blank and repeat_prev are all 0. The mode codes are 00 normal, 01 16-luminance, 10 9-colour and 11 16-hue.
- R2: A write whose field equals the most recently scheduled mode is ignored. It schedules nothing and changes no output.
- R3: For a write at position H (the hpos value on the write cycle), a change from 00 to 01 or to 11 appears cleanly in slot H+4. Slot H+3 still shows 00.
- R4: A change from 00 to 10 appears cleanly in slot H+3.
- R5: For a change from 01 or 11 to 00, slot H+3 keeps the outgoing mode with half_cut=1 and pf_blank=1.
- R6: In the slot after a half-cut slot, mode_eff is 00 and repeat_prev=1. From the following slot the display is clean.
- R7: A change from 10 to 00 shows mode 00 in slot H+4 with pf_blank=1 for that slot only.
- R8: A change between two different non-zero modes appears cleanly in slot H+4.
- R9: For every slot, hires_eff equals hires_req when the slot's mode is 00, and is 0 otherwise.
- R10: Each queued change keeps its own delay, classified against the previously scheduled mode. It never lands before the slot that follows the previous change's last affected slot (a wide exit occupies two slots).
- R11: Up to QDEPTH changes can be pending. A write that arrives while the queue is full is dropped.
- R12: A slot is taken only on a cycle with cc_en=1. With cc_en=0 all outputs hold, and hpos does not count as a slot.
- R13: Target positions wrap modulo LINE_CLKS. A write at position $80 from 00 to 01 lands at $84, inside the $83 to $85 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_wr | input | 1 | Write strobe for the priority register's mode field |
| prio_wmode | input | 2 | Mode field written (00/01/10/11) |
| cc_en | input | 1 | Color-clock enable; one slot per enabled cycle |
| hpos | input | POS_W | Horizontal position of the current slot |
| hires_req | input | 1 | High-resolution request from the display-list processor |
| mode_eff | output | 2 | Effective display mode for the slot |
| hires_eff | output | 1 | Effective high-resolution enable |
| half_cut | output | 1 | Outgoing-mode pixel shown at half width in this slot |
| pf_blank | output | 1 | Playfield suppressed in this slot |
| repeat_prev | output | 1 | Slot shows the previous slot's pixel data |

## Verification
The bench builds the block with LINE_CLKS=228 and QDEPTH=3. The shallow queue lets three back-to-back writes fill it and a fourth one be dropped. The full line length makes the end-of-line wrap at positions 226 and 227 reachable within a few hundred cycles. The rest of the run mixes bursty writes with gapped color-clock enables, where the spacing rule between queued changes and the held outputs interact.

// File: rtl/mdsw_pkg.sv
package mdsw_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'b00,
        MD_LUMA   = 2'b01,
        MD_NINE   = 2'b10,
        MD_HUE    = 2'b11
    } disp_mode_e;

    typedef enum logic [1:0] {
        XK_CLEAN     = 2'b00,
        XK_WIDE_EXIT = 2'b01,
        XK_NINE_EXIT = 2'b10
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_REPEAT = 2'b10
    } slot_state_e;

    typedef struct packed {
        disp_mode_e mode;
        xfer_kind_e kind;
    } change_t;

    // Number of slots a change occupies on screen.
    function automatic logic [1:0] kind_span(input xfer_kind_e k);
        return (k == XK_WIDE_EXIT) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/mdsw_xfer_classify.sv
module mdsw_xfer_classify
    import mdsw_pkg::*;
#(
    parameter int LEAD_W    = 9,
    parameter int DLY_SHORT = 3,
    parameter int DLY_STD   = 4
) (
    input  disp_mode_e        from_mode,
    input  disp_mode_e        to_mode,
    output logic [LEAD_W-1:0] lead,
    output xfer_kind_e        kind
);

    logic from_wide;
    assign from_wide = (from_mode == MD_LUMA) || (from_mode == MD_HUE);

    always_comb begin
        lead = LEAD_W'(DLY_STD);
        kind = XK_CLEAN;
        if (from_mode == MD_NORMAL && to_mode == MD_NINE) begin
            lead = LEAD_W'(DLY_SHORT);
        end else if (from_wide && to_mode == MD_NORMAL) begin
            lead = LEAD_W'(DLY_SHORT);
            kind = XK_WIDE_EXIT;
        end else if (from_mode == MD_NINE && to_mode == MD_NORMAL) begin
            kind = XK_NINE_EXIT;
        end
    end

endmodule

// File: rtl/mdsw_change_fifo.sv
module mdsw_change_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_data = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (do_push && wr_ptr == PTR_W'(g)) begin
                slots[g] <= push_data;
            end
        end
    end

endmodule

// File: rtl/mdsw_slot_fsm.sv
module mdsw_slot_fsm
    import mdsw_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cc_en,
    input  logic             hires_req,
    input  logic [POS_W-1:0] hpos,
    input  logic             head_valid,
    input  logic [POS_W-1:0] head_tgt,
    input  change_t          head_chg,
    output logic             pop,
    output disp_mode_e       mode_q,
    output logic             hires_q,
    output logic             cut_q,
    output logic             blank_q,
    output logic             rep_q
);

    slot_state_e state;
    slot_state_e state_nxt;
    logic        hit;
    disp_mode_e  slot_mode;
    logic        slot_cut;
    logic        slot_blank;
    logic        slot_rep;

    assign hit = cc_en && (state == ST_ARMED) && head_valid && (head_tgt == hpos);
    assign pop = hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (head_valid) state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit && head_chg.kind == XK_WIDE_EXIT) state_nxt = ST_REPEAT;
                else if (!head_valid)                    state_nxt = ST_IDLE;
            end
            ST_REPEAT: begin
                if (cc_en) state_nxt = ST_ARMED;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Slot content decode
    always_comb begin
        slot_mode  = mode_q;
        slot_cut   = 1'b0;
        slot_blank = 1'b0;
        slot_rep   = 1'b0;
        if (state == ST_REPEAT) begin
            slot_mode = MD_NORMAL;
            slot_rep  = 1'b1;
        end else if (hit) begin
            unique case (head_chg.kind)
                XK_CLEAN: begin
                    slot_mode = head_chg.mode;
                end
                XK_WIDE_EXIT: begin
                    slot_cut   = 1'b1;
                    slot_blank = 1'b1;
                end
                XK_NINE_EXIT: begin
                    slot_mode  = MD_NORMAL;
                    slot_blank = 1'b1;
                end
                default: begin
                    slot_mode = head_chg.mode;
                end
            endcase
        end
    end

    // Output registers, advanced once per color clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MD_NORMAL;
            hires_q <= 1'b0;
            cut_q   <= 1'b0;
            blank_q <= 1'b0;
            rep_q   <= 1'b0;
        end else if (cc_en) begin
            mode_q  <= slot_mode;
            hires_q <= hires_req && (slot_mode == MD_NORMAL);
            cut_q   <= slot_cut;
            blank_q <= slot_blank;
            rep_q   <= slot_rep;
        end
    end

endmodule

// File: rtl/mode_switch_delay.sv
module mode_switch_delay
    import mdsw_pkg::*;
#(
    parameter int LINE_CLKS = 228,
    parameter int POS_W     = 8,
    parameter int QDEPTH    = 4,
    parameter int DLY_SHORT = 3,
    parameter int DLY_STD   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_wr,
    input  logic [MODE_W-1:0] prio_wmode,
    input  logic              cc_en,
    input  logic [POS_W-1:0]  hpos,
    input  logic              hires_req,
    output logic [MODE_W-1:0] mode_eff,
    output logic              hires_eff,
    output logic              half_cut,
    output logic              pf_blank,
    output logic              repeat_prev
);

    localparam int DIST_W  = POS_W + 1;
    localparam int SUM_W   = POS_W + 2;
    localparam int CHG_W   = $bits(change_t);
    localparam int ENTRY_W = POS_W + CHG_W;

    disp_mode_e         req_mode;
    disp_mode_e         sched_mode;
    disp_mode_e         mode_q;
    logic [DIST_W-1:0]  lead;
    xfer_kind_e         new_kind;
    logic [POS_W-1:0]   last_free;
    logic [DIST_W-1:0]  free_dist;
    logic [DIST_W-1:0]  gap;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   sum_wrap;
    logic [POS_W-1:0]   new_tgt;
    logic [SUM_W-1:0]   free_sum;
    change_t            new_chg;
    logic [ENTRY_W-1:0] push_entry;
    logic [ENTRY_W-1:0] head_entry;
    logic [POS_W-1:0]   head_tgt;
    change_t            head_chg;
    logic               q_empty;
    logic               q_full;
    logic               accept;
    logic               pop;

    // Forward distance from position p to target t around the line.
    function automatic logic [DIST_W-1:0] ahead(input logic [POS_W-1:0] t,
                                                input logic [POS_W-1:0] p);
        if (t >= p) return DIST_W'(t) - DIST_W'(p);
        return DIST_W'(t) + DIST_W'(LINE_CLKS) - DIST_W'(p);
    endfunction

    function automatic logic [SUM_W-1:0] wrap_line(input logic [SUM_W-1:0] v);
        return (v >= SUM_W'(LINE_CLKS)) ? v - SUM_W'(LINE_CLKS) : v;
    endfunction

    assign req_mode = disp_mode_e'(prio_wmode);

    mdsw_xfer_classify #(
        .LEAD_W    (DIST_W),
        .DLY_SHORT (DLY_SHORT),
        .DLY_STD   (DLY_STD)
    ) u_classify (
        .from_mode (sched_mode),
        .to_mode   (req_mode),
        .lead      (lead),
        .kind      (new_kind)
    );

    // Spacing: never before the slot after the previous change's last slot.
    assign free_dist = ahead(last_free, hpos);
    assign gap       = (!q_empty && free_dist > lead) ? free_dist : lead;
    assign sum       = SUM_W'(hpos) + SUM_W'(gap);
    assign sum_wrap  = wrap_line(sum);
    assign new_tgt   = POS_W'(sum_wrap);
    assign free_sum  = wrap_line(SUM_W'(new_tgt) + SUM_W'(kind_span(new_kind)));

    assign new_chg.mode = req_mode;
    assign new_chg.kind = new_kind;
    assign push_entry   = {new_tgt, new_chg};
    assign accept       = prio_wr && (req_mode != sched_mode) && !q_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sched_mode <= MD_NORMAL;
            last_free  <= '0;
        end else if (accept) begin
            sched_mode <= req_mode;
            last_free  <= POS_W'(free_sum);
        end
    end

    mdsw_change_fifo #(
        .DEPTH (QDEPTH),
        .DW    (ENTRY_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (push_entry),
        .pop       (pop),
        .head_data (head_entry),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign head_tgt = head_entry[ENTRY_W-1 -: POS_W];
    assign head_chg = change_t'(head_entry[CHG_W-1:0]);

    mdsw_slot_fsm #(
        .POS_W (POS_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cc_en      (cc_en),
        .hires_req  (hires_req),
        .hpos       (hpos),
        .head_valid (!q_empty),
        .head_tgt   (head_tgt),
        .head_chg   (head_chg),
        .pop        (pop),
        .mode_q     (mode_q),
        .hires_q    (hires_eff),
        .cut_q      (half_cut),
        .blank_q    (pf_blank),
        .rep_q      (repeat_prev)
    );

    assign mode_eff = mode_q;

endmodule

// File: rtl/mdsw_checker.sv
module mdsw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cc_en,
    input logic [1:0] mode_eff,
    input logic       hires_eff,
    input logic       half_cut,
    input logic       pf_blank,
    input logic       repeat_prev
);

    // R9
    hires_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff != 2'b00) |-> !hires_eff);

    // R5
    cut_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_cut |-> (pf_blank && mode_eff != 2'b00 && !repeat_prev));

    // R6
    cut_then_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && half_cut) |=> (repeat_prev && mode_eff == 2'b00 && !half_cut));

    // R6
    repeat_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_prev |-> (mode_eff == 2'b00 && !pf_blank));

    // R7
    nine_exit_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_blank && !half_cut) |-> (mode_eff == 2'b00));

    // R12
    hold_without_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_en |=> ($stable(mode_eff) && $stable(hires_eff) && $stable(half_cut)
                    && $stable(pf_blank) && $stable(repeat_prev)));

endmodule

bind mode_switch_delay mdsw_checker u_mdsw_chk (.*);

// File: tb/tb_mode_switch_delay.sv
module tb_mode_switch_delay;

    localparam int CLK_PERIOD = 10;
    localparam int LINE       = 228;
    localparam int QD         = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prio_wr = 1'b0;
    logic [1:0] prio_wmode = 2'b00;
    logic       cc_en = 1'b0;
    logic [7:0] hpos = 8'd0;
    logic       hires_req = 1'b0;
    logic [1:0] mode_eff;
    logic       hires_eff;
    logic       half_cut;
    logic       pf_blank;
    logic       repeat_prev;

    int    checks = 0;
    int    errors = 0;
    int    pos = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    // Behavioural reference state
    int q_tgt[$];
    int q_mode[$];
    int q_kind[$];   // 0 clean, 1 wide exit, 2 nine exit
    int m_sched, m_mode;
    bit m_hires, m_cut, m_blank, m_rep, m_repflag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mode_switch_delay #(
        .LINE_CLKS (LINE),
        .POS_W     (8),
        .QDEPTH    (QD),
        .DLY_SHORT (3),
        .DLY_STD   (4)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_wr     (prio_wr),
        .prio_wmode  (prio_wmode),
        .cc_en       (cc_en),
        .hpos        (hpos),
        .hires_req   (hires_req),
        .mode_eff    (mode_eff),
        .hires_eff   (hires_eff),
        .half_cut    (half_cut),
        .pf_blank    (pf_blank),
        .repeat_prev (repeat_prev)
    );

    function automatic int fwd(int t, int p);
        return (t >= p) ? t - p : t + LINE - p;
    endfunction

    task automatic model_clear();
        q_tgt.delete(); q_mode.delete(); q_kind.delete();
        m_sched = 0; m_mode = 0;
        m_hires = 0; m_cut = 0; m_blank = 0; m_rep = 0; m_repflag = 0;
    endtask

    // One clock edge of the reference, using the inputs now driven.
    task automatic model_step();
        int  nm, lead, kind, gap, tgt;
        bit  do_push;
        if (!rst_n) begin
            model_clear();
            return;
        end
        nm = int'(prio_wmode);
        do_push = prio_wr && (nm != m_sched) && (q_tgt.size() < QD);
        lead = 4; kind = 0; tgt = 0;
        if (do_push) begin
            if (m_sched == 0 && nm == 2) lead = 3;
            else if ((m_sched == 1 || m_sched == 3) && nm == 0) begin lead = 3; kind = 1; end
            else if (m_sched == 2 && nm == 0) kind = 2;
            gap = lead;
            if (q_tgt.size() > 0) begin
                int tend;
                tend = fwd(q_tgt[q_tgt.size()-1], int'(hpos))
                       + ((q_kind[q_kind.size()-1] == 1) ? 2 : 1);
                if (tend > gap) gap = tend;
            end
            tgt = (int'(hpos) + gap) % LINE;
        end
        if (cc_en) begin
            m_cut = 0; m_blank = 0; m_rep = 0;
            if (m_repflag) begin
                m_mode = 0; m_rep = 1; m_repflag = 0;
            end else if (q_tgt.size() > 0 && q_tgt[0] == int'(hpos)) begin
                case (q_kind[0])
                    0: m_mode = q_mode[0];
                    1: begin m_cut = 1; m_blank = 1; m_repflag = 1; end
                    default: begin m_mode = 0; m_blank = 1; end
                endcase
                void'(q_tgt.pop_front()); void'(q_mode.pop_front()); void'(q_kind.pop_front());
            end
            m_hires = hires_req && (m_mode == 0);
        end
        if (do_push) begin
            q_tgt.push_back(tgt); q_mode.push_back(nm); q_kind.push_back(kind);
            m_sched = nm;
        end
    endtask

    task automatic compare();
        checks++;
        if (mode_eff !== 2'(m_mode) || hires_eff !== m_hires || half_cut !== m_cut
            || pf_blank !== m_blank || repeat_prev !== m_rep) begin
            errors++;
            $display("FAIL %s t=%0t: actual mode=%0d hires=%0b cut=%0b blank=%0b rep=%0b expected mode=%0d hires=%0b cut=%0b blank=%0b rep=%0b",
                     cur_tag, $time, mode_eff, hires_eff, half_cut, pf_blank, repeat_prev,
                     m_mode, m_hires, m_cut, m_blank, m_rep);
        end
    endtask

    // Drive one cycle at the negative edge, step the reference, compare at the next one.
    task automatic tick(bit we, int md, bit ce);
        prio_wr    = we;
        prio_wmode = 2'(md);
        cc_en      = ce;
        hpos       = 8'(pos);
        model_step();
        if (ce) pos = (pos + 1) % LINE;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 1);
    endtask

    task automatic write_at(int h, int md);
        while (pos != h) tick(0, 0, 1);
        tick(1, md, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual run still active expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) tick(0, 0, 1);
        rst_n = 1'b1;
        idle(4);
        // R9: high-resolution request passes in normal mode
        cur_tag = "R9";
        hires_req = 1'b1;
        idle(5);
        // R13: write at $80, 00 -> 01 lands at $84 (R3 timing)
        cur_tag = "R13";
        write_at(8'h80, 1);
        idle(8);
        // R5 / R6: 01 -> 00 wide exit
        cur_tag = "R5";
        write_at(150, 0);
        idle(3);
        cur_tag = "R6";
        idle(5);
        // R4: 00 -> 10
        cur_tag = "R4";
        write_at(170, 2);
        idle(6);
        // R7: 10 -> 00
        cur_tag = "R7";
        write_at(180, 0);
        idle(7);
        // R3: 00 -> 11
        cur_tag = "R3";
        write_at(190, 3);
        idle(6);
        // R8: nonzero to nonzero
        cur_tag = "R8";
        write_at(200, 1);
        idle(6);
        write_at(210, 2);
        idle(6);
        cur_tag = "R7";
        write_at(220, 0);
        idle(7);
        // R2: same-mode write ignored
        cur_tag = "R2";
        write_at(10, 0);
        idle(8);
        // R10: back-to-back changes keep their own delays
        cur_tag = "R10";
        write_at(30, 1);
        tick(1, 0, 1);
        tick(1, 2, 1);
        idle(20);
        // R11: burst beyond capacity, extra writes dropped
        cur_tag = "R11";
        write_at(60, 3);
        tick(1, 0, 1);
        tick(1, 1, 1);
        tick(1, 2, 1);
        tick(1, 0, 1);
        idle(30);
        // R12: gapped color clocks
        cur_tag = "R12";
        for (int i = 0; i < 300; i++) begin
            tick((i % 17) == 5, (i / 17) % 4, (i % 3) != 0);
            if ((i % 11) == 0) hires_req = ~hires_req;
        end
        idle(10);
        // R13: targets that wrap past the end of the line
        cur_tag = "R13";
        write_at(226, 2);
        idle(10);
        write_at(227, 0);
        idle(10);
        write_at(225, 3);
        idle(4);
        tick(1, 0, 1);
        idle(12);
        // R10: mixed stimulus
        cur_tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            hires_req = ($urandom % 4) != 0;
            tick(($urandom % 6) == 0, int'($urandom % 4), ($urandom % 5) != 0);
        end
        idle(20);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule